// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block produces the system reset for a small processor supervisor. It merges three reasons to hold the system in reset: a supply-low flag that is already synchronous to the clock, an active-low push-button reset input, and a watchdog. The watchdog expects the software to keep toggling a strobe pin. Whichever source is active, the reset is held. Once the last source goes away, the reset is kept for a further recovery period before it is released.

All timing is counted in pulses of a clock-enable tick. The recovery period (`REC_TICKS`) and the watchdog timeout (`WDT_TICKS`) are parameters, so a slow tick gives real-time delays while a simulation can use small counts. The push-button and strobe inputs are asynchronous, so each passes through a flop synchronizer before the block uses it. The reset is driven out in both polarities and as an internal flag.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `rst_active` is 1 and `rst_out_n` is 0. After `rst_n` rises, with a tick every cycle, `rst_out_n` goes high on the `REC_TICKS`-th rising clock edge.
- R2: When `supply_low` is 1, `rst_active` is 1 from the next clock edge on, and stays 1 while the flag stays set. With a tick every cycle, reset releases on the `REC_TICKS`-th edge after the flag clears, whatever the flag's pulse width was.
- R3: `man_rst_n` passes through `SYNC_STAGES` (2) flops. Reset asserts on the third edge that samples it low and is held while it stays low. With a tick every cycle, reset releases on edge `REC_TICKS`+2 after the input returns high.
- R4: If the strobe stays at one level, either 0 or 1, the watchdog fires on the `WDT_TICKS`-th edge after reset release, with a tick every cycle. It then produces a reset pulse that lasts `REC_TICKS` edges.
- R5: Every rising edge and every falling edge of the synchronized strobe restarts the watchdog. With a tick every cycle, toggling the strobe every P cycles never fires the watchdog when P <= `WDT_TICKS`, and always fires it when P > `WDT_TICKS`.
- R6: The watchdog count is held at zero while reset is asserted, so a full timeout is always measured from the moment reset is released.
- R7: A source that becomes active during recovery restarts the recovery count. Release then comes `REC_TICKS` ticks after that source has cleared.
- R8: `rst_out` is always the exact complement of `rst_out_n`, and `rst_active` equals `rst_out`.
- R9: Recovery and watchdog counts advance only in cycles where `tick_en` is 1. With `tick_en` held at 0, a pending recovery never completes and a static strobe never fires the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset of the block |
| tick_en | input | 1 | Clock enable that paces both timers |
| supply_low | input | 1 | Synchronous supply-below-threshold flag, active high |
| man_rst_n | input | 1 | Asynchronous push-button reset, active low |
| wdt_strobe | input | 1 | Asynchronous watchdog strobe from software |
| rst_out_n | output | 1 | System reset, active low |
| rst_out | output | 1 | System reset, active high |
| rst_active | output | 1 | Internal flag, 1 while reset is asserted |

## Verification
The bench drives supply-low pulses of several widths and push-button pulses. It measures the release edge for each, which shows whether the synchronizer delay is applied to one source and not the other. It sweeps the strobe toggle period from one cycle to just past the timeout. This shows exactly where the boundary sits between a watchdog that is kept quiet and one that fires, and also shows whether a restart on one edge only would be caught. It holds the strobe static at both levels, injects sources at every offset inside recovery, and holds the tick enable low. These patterns separate a correct reload and tick gating from timers that keep counting.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // One bit per reason for holding the system in reset.
    typedef struct packed {
        logic supply;
        logic manual;
        logic watchdog;
    } src_t;

    function automatic logic any_src(input src_t s);
        return s.supply | s.manual | s.watchdog;
    endfunction

endpackage

// File: rtl/sup_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
module sup_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.pipe[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            state_d.pipe[i] = state_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pipe <= {STAGES{INIT}};
        end else begin
            state_q <= state_d;
        end
    end

    assign dout = state_q.pipe[STAGES-1];

endmodule

// File: rtl/sup_wdt.sv
// Watchdog: counts ticks since the last strobe transition.
module sup_wdt #(
    parameter int unsigned WDT_TICKS = 1600,
    localparam int unsigned CNT_W = $clog2(WDT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             strobe_s,
    input  logic             hold_clr,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WDT_TICKS - 1);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;
    logic   strobe_edge;
    logic   fire;

    always_comb begin
        state_d     = state_q;
        strobe_edge = strobe_s ^ state_q.prev;
        fire        = tick_en && !hold_clr && !strobe_edge && (state_q.cnt == LAST);
        state_d.prev = strobe_s;
        if (hold_clr || strobe_edge || fire) begin
            state_d.cnt = '0;
        end else if (tick_en) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.prev <= 1'b0;
            state_q.cnt  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign expire = fire;
    assign cnt    = state_q.cnt;

endmodule

// File: rtl/sup_recovery.sv
// Holds reset while any source is active, then stretches it.
module sup_recovery #(
    parameter int unsigned REC_TICKS = 200,
    localparam int unsigned CNT_W = $clog2(REC_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             src_any,
    output logic             active,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_TICKS - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (src_any) begin
            state_d.active = 1'b1;
            state_d.cnt    = '0;
        end else if (state_q.active && tick_en) begin
            if (state_q.cnt == LAST) begin
                state_d.active = 1'b0;
                state_d.cnt    = '0;
            end else begin
                state_d.cnt = state_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.active <= 1'b1;
            state_q.cnt    <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign active = state_q.active;
    assign cnt    = state_q.cnt;

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int unsigned REC_TICKS   = 200,
    parameter int unsigned WDT_TICKS   = 1600,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic supply_low,
    input  logic man_rst_n,
    input  logic wdt_strobe,
    output logic rst_out_n,
    output logic rst_out,
    output logic rst_active
);

    localparam int unsigned REC_W = $clog2(REC_TICKS + 1);
    localparam int unsigned WDT_W = $clog2(WDT_TICKS + 1);
    localparam int unsigned MAN_B = 1;
    localparam int unsigned STB_B = 0;

    logic [1:0]       sync_in;
    logic [1:0]       sync_out;
    logic             wdt_expire;
    logic [WDT_W-1:0] wdt_cnt;
    logic [REC_W-1:0] rec_cnt;
    logic             rec_active;
    src_t             src;
    logic             src_any;

    assign sync_in[MAN_B] = man_rst_n;
    assign sync_in[STB_B] = wdt_strobe;

    sup_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .INIT   (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .dout  (sync_out)
    );

    sup_wdt #(
        .WDT_TICKS (WDT_TICKS)
    ) u_wdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .strobe_s (sync_out[STB_B]),
        .hold_clr (rec_active),
        .expire   (wdt_expire),
        .cnt      (wdt_cnt)
    );

    always_comb begin
        src.supply   = supply_low;
        src.manual   = ~sync_out[MAN_B];
        src.watchdog = wdt_expire;
        src_any      = any_src(src);
    end

    sup_recovery #(
        .REC_TICKS (REC_TICKS)
    ) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .src_any (src_any),
        .active  (rec_active),
        .cnt     (rec_cnt)
    );

    assign rst_active = rec_active;
    assign rst_out    = rec_active;
    assign rst_out_n  = ~rec_active;

endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
    parameter int unsigned REC_TICKS = 200,
    parameter int unsigned WDT_TICKS = 1600,
    localparam int unsigned REC_W = $clog2(REC_TICKS + 1),
    localparam int unsigned WDT_W = $clog2(WDT_TICKS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             supply_low,
    input logic             man_rst_n,
    input logic             rst_active,
    input logic             src_any,
    input logic             wdt_expire,
    input logic [WDT_W-1:0] wdt_cnt,
    input logic [REC_W-1:0] rec_cnt
);

    logic [1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q != 2'd3) begin
            since_q <= since_q + 2'd1;
        end
    end

    p_supply_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> rst_active);

    p_manual_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd3 && !$past(man_rst_n, 3)) |-> rst_active);

    p_expire_resets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expire |=> rst_active);

    p_wdt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_cnt < WDT_W'(WDT_TICKS));

    p_wdt_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> (wdt_cnt == '0));

    p_release_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active) |-> ($past(!src_any) && $past(tick_en)
                               && $past(rec_cnt) == REC_W'(REC_TICKS - 1)));

    p_tick_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_active && !src_any && !tick_en) |=> (rst_active && $stable(rec_cnt)));

endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(
    .REC_TICKS (REC_TICKS),
    .WDT_TICKS (WDT_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .supply_low (supply_low),
    .man_rst_n  (man_rst_n),
    .rst_active (rst_active),
    .src_any    (src_any),
    .wdt_expire (wdt_expire),
    .wdt_cnt    (wdt_cnt),
    .rec_cnt    (rec_cnt)
);

// File: tb/sup_reset_ctrl_tb.sv
`timescale 1ns/1ps
module sup_reset_ctrl_tb;

    localparam int REC = 5;
    localparam int WDT = 8;

    logic clk = 1'b0;
    logic rst_n, tick_en, supply_low, man_rst_n, wdt_strobe;
    logic rst_out_n, rst_out, rst_active;
    logic kick = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    sup_reset_ctrl #(
        .REC_TICKS   (REC),
        .WDT_TICKS   (WDT),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .supply_low (supply_low),
        .man_rst_n  (man_rst_n),
        .wdt_strobe (wdt_strobe),
        .rst_out_n  (rst_out_n),
        .rst_out    (rst_out),
        .rst_active (rst_active)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // advance one edge; sample 1 ns after it; R8 checked on every sample
    task automatic step();
        @(posedge clk);
        #1;
        check(rst_out === ~rst_out_n && rst_active === rst_out, "R8 polarity",
              int'(rst_out), int'(~rst_out_n));
    endtask

    task automatic edges_to_release(output int n);
        n = 0;
        while (rst_out_n !== 1'b1 && n < 1000) begin
            step();
            n++;
        end
    endtask

    task automatic edges_to_assert(output int n);
        n = 0;
        while (rst_out_n !== 1'b0 && n < 1000) begin
            step();
            n++;
        end
    endtask

    task automatic supply_pulse(input int width);
        supply_low = 1'b1;
        repeat (width) step();
        supply_low = 1'b0;
    endtask

    // background strobe toggler, period one cycle
    always @(posedge clk) begin
        #1;
        if (kick) wdt_strobe = ~wdt_strobe;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        bit saw;
        rst_n = 1'b0; tick_en = 1'b1; supply_low = 1'b0;
        man_rst_n = 1'b1; wdt_strobe = 1'b0;
        repeat (3) step();
        // R1: reset state
        check(rst_out_n === 1'b0 && rst_active === 1'b1, "R1 reset state",
              int'(rst_out_n), 0);
        kick = 1'b1;
        rst_n = 1'b1;
        edges_to_release(n);
        check(n == REC, "R1 power-on release", n, REC);

        // R2: supply flag, several widths
        for (int w = 1; w <= 6; w++) begin
            supply_low = 1'b1;
            step();
            check(rst_out_n === 1'b0, "R2 assert next edge", int'(rst_out_n), 0);
            for (int k = 1; k < w; k++) begin
                step();
                check(rst_out_n === 1'b0, "R2 held", int'(rst_out_n), 0);
            end
            supply_low = 1'b0;
            edges_to_release(n);
            check(n == REC, "R2 release", n, REC);
        end

        // R3: push-button through the synchronizer
        for (int w = 1; w <= 4; w++) begin
            man_rst_n = 1'b0;
            edges_to_assert(n);
            check(n == 3, "R3 assert delay", n, 3);
            repeat (w) begin
                step();
                check(rst_out_n === 1'b0, "R3 held", int'(rst_out_n), 0);
            end
            man_rst_n = 1'b1;
            edges_to_release(n);
            check(n == REC + 2, "R3 release", n, REC + 2);
        end

        // R7: new source at each offset inside recovery
        for (int k = 0; k <= REC - 2; k++) begin
            supply_pulse(1);
            repeat (k) step();
            check(rst_out_n === 1'b0, "R7 still recovering", int'(rst_out_n), 0);
            supply_pulse(1);
            edges_to_release(n);
            check(n == REC, "R7 reload", n, REC);
        end

        // R4/R6: static strobe at both levels
        for (int lvl = 0; lvl < 2; lvl++) begin
            kick = 1'b0;
            wdt_strobe = lvl[0];
            supply_pulse(1);
            repeat (2 * WDT) step();
            supply_pulse(1);
            edges_to_release(n);
            check(n == REC, "R6 release before timeout", n, REC);
            edges_to_assert(n);
            check(n == WDT, "R4 R6 timeout from release", n, WDT);
            edges_to_release(n);
            check(n == REC, "R4 watchdog pulse length", n, REC);
            kick = 1'b1;
        end

        // R5: sweep toggle period across the timeout boundary
        for (int p = 1; p <= WDT + 3; p++) begin
            kick = 1'b0;
            supply_pulse(1);
            edges_to_release(n);
            wdt_strobe = ~wdt_strobe;
            saw = 1'b0;
            for (int c = 1; c <= 3 * (WDT + 4); c++) begin
                step();
                if (rst_out_n === 1'b0) saw = 1'b1;
                if (c % p == 0) wdt_strobe = ~wdt_strobe;
            end
            check(saw == (p > WDT), "R5 toggle period sweep", int'(saw), int'(p > WDT));
            kick = 1'b1;
            edges_to_release(n);
        end

        // R9: no tick, no progress
        kick = 1'b0;
        tick_en = 1'b0;
        repeat (4 * WDT) step();
        check(rst_out_n === 1'b1, "R9 watchdog frozen", int'(rst_out_n), 1);
        supply_pulse(2);
        repeat (4 * REC) step();
        check(rst_out_n === 1'b0, "R9 recovery frozen", int'(rst_out_n), 0);
        kick = 1'b1;
        tick_en = 1'b1;
        edges_to_release(n);
        check(n == REC, "R9 resumes with tick", n, REC);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule